// File: doc/BRIEF.md
# Rotate, Shift and Nibble-Rotate Unit

This block is a purely combinational datapath slice for an 8-bit processor core. It performs every single-bit rotate and shift on one byte, and the two four-bit rotates that move nibbles between the accumulator and a memory byte. It also builds the new flag byte that each of these operations produces. The surrounding core decodes the opcode, fetches the memory byte and writes the results back. This unit sees only the values and a compact selector.

A two-bit mode picks one of four behaviours:

- The full-flag form works on any operand byte.
- The fast accumulator form works on the accumulator and keeps the sign, zero and parity flags untouched.
- The left nibble rotate and the right nibble rotate each produce both a new memory byte and a new accumulator.

A three-bit code selects the shift kind in the first two modes. The set of codes includes the uncommon left shift that fills bit 0 with a one.

The unit has no clock, no state and no handshake. Every output is a pure function of the current inputs, so the caller can register it wherever its own pipeline puts the boundary. The stream conventions of the wider design therefore do not apply at this edge.

Top module: `rot_nib_unit`

## Requirements
- R1: Code 000 rotates left and code 001 rotates right; in both the bit that leaves the byte is written to carry (flag bit 0) and to the vacated bit position.
- R2: Code 010 rotates left and code 011 rotates right through carry: carry-in (flags_in bit 0) enters the vacated bit and the bit that leaves becomes the new carry.
- R3: Code 100 shifts left inserting 0 at bit 0; code 101 shifts right keeping bit 7 unchanged; carry takes the bit that leaves.
- R4: Code 110 shifts left inserting 1 at bit 0; code 111 shifts right inserting 0 at bit 7, so the sign flag ends at 0.
- R5: The flag byte is laid out as bit 7 sign, bit 6 zero, bit 5 copy of result bit 5, bit 4 half-carry, bit 3 copy of result bit 3, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. In full mode these are sign = result bit 7, zero = result is 0, parity = 1 for an even count of ones, half-carry = 0 and subtract = 0. In full mode result_out is the shifted operand and acc_out equals acc_in.
- R6: mode_sel encoding: 00 full-flag form on operand_in, 01 fast accumulator form, 10 left nibble rotate, 11 right nibble rotate.
- R7: In fast mode the rotate acts on acc_in and drives both result_out and acc_out. Sign, zero and parity are copied from flags_in, half-carry and subtract are cleared, carry takes the bit that leaves, and flag bits 5 and 3 copy the result.
- R8: In fast mode only shift_code[1:0] is used, so a code with bit 2 set behaves as the same code with bit 2 cleared.
- R9: Left nibble rotate: result_out = {operand_in[3:0], acc_in[3:0]} and acc_out = {acc_in[7:4], operand_in[7:4]}.
- R10: Right nibble rotate: result_out = {acc_in[3:0], operand_in[7:4]} and acc_out = {acc_in[7:4], operand_in[3:0]}.
- R11: In both nibble rotates sign, zero, parity and flag bits 5 and 3 follow acc_out, half-carry and subtract are cleared, and carry is copied from flags_in bit 0.
- R12: operand_in has no effect in fast mode and shift_code has no effect in nibble modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel | input | 2 | Operation family, encoded as in R6 |
| shift_code | input | 3 | Shift kind for the full and fast modes |
| operand_in | input | 8 | Operand byte, or the memory byte in nibble modes |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current flag byte; bit 0 is the carry-in |
| result_out | output | 8 | Shifted byte, or the new memory byte in nibble modes |
| acc_out | output | 8 | New accumulator value |
| flags_out | output | 8 | New flag byte |

## Verification
Two functions can fall in the same evaluation. In the through-carry rotates, the old carry is consumed into the vacated bit while the new carry is produced from the bit that leaves. In the nibble rotates, two destination bytes are written together while the carry passes through untouched. Both cases are provoked by sweeping every operand value with carry-in held at 0 and then at 1. Each case is judged by comparing all three outputs against an independent bench model, so a swap between the old carry and the new carry is caught. Directed vectors with hand-computed bytes add checks at the extremes 0x00, 0x80, 0x81 and 0xFF.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned MODE_W = 2;

  // flag byte bit positions
  localparam int unsigned FL_S = 7;
  localparam int unsigned FL_Z = 6;
  localparam int unsigned FL_5 = 5;
  localparam int unsigned FL_H = 4;
  localparam int unsigned FL_3 = 3;
  localparam int unsigned FL_P = 2;
  localparam int unsigned FL_N = 1;
  localparam int unsigned FL_C = 0;

  typedef enum logic [MODE_W-1:0] {
    MODE_FULL  = 2'b00,
    MODE_ACC   = 2'b01,
    MODE_NIB_L = 2'b10,
    MODE_NIB_R = 2'b11
  } mode_e;

  typedef enum logic [CODE_W-1:0] {
    SC_ROT_L   = 3'b000,
    SC_ROT_R   = 3'b001,
    SC_THRU_L  = 3'b010,
    SC_THRU_R  = 3'b011,
    SC_ARITH_L = 3'b100,
    SC_ARITH_R = 3'b101,
    SC_ONES_L  = 3'b110,
    SC_LOGIC_R = 3'b111
  } code_e;

  function automatic logic even_ones(input logic [DATA_W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/rsn_shifter.sv
module rsn_shifter
  import rsn_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] din,
  input  logic         cin,
  input  code_e        code,
  output logic [W-1:0] dout,
  output logic         cout
);
  localparam int unsigned MSB = W - 1;

  logic fill;
  logic go_right;

  assign go_right = code[0];

  // choose the bit that enters the vacated end
  always_comb begin
    unique case (code)
      SC_ROT_L:   fill = din[MSB];
      SC_ROT_R:   fill = din[0];
      SC_THRU_L:  fill = cin;
      SC_THRU_R:  fill = cin;
      SC_ARITH_L: fill = 1'b0;
      SC_ARITH_R: fill = din[MSB];
      SC_ONES_L:  fill = 1'b1;
      SC_LOGIC_R: fill = 1'b0;
      default:    fill = 1'b0;
    endcase
  end

  always_comb begin
    if (go_right) begin
      dout = {fill, din[MSB:1]};
      cout = din[0];
    end else begin
      dout = {din[MSB-1:0], fill};
      cout = din[MSB];
    end
  end

  always_comb begin
    if (!$isunknown({din, cin, code})) begin
      // R2
      thru_entry_chk: assert (!(code inside {SC_THRU_L, SC_THRU_R}) ||
                              (go_right ? dout[MSB] : dout[0]) == cin)
        else $error("through-carry rotate lost the incoming carry");
    end
  end
endmodule

// File: rtl/rsn_nibble.sv
module rsn_nibble
  import rsn_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         dir_right,
  input  logic [W-1:0] mem_in,
  input  logic [W-1:0] acc_in,
  output logic [W-1:0] mem_out,
  output logic [W-1:0] acc_out
);
  localparam int unsigned H = W / 2;

  logic [H-1:0] mem_hi, mem_lo, acc_hi, acc_lo;

  assign mem_hi = mem_in[W-1:H];
  assign mem_lo = mem_in[H-1:0];
  assign acc_hi = acc_in[W-1:H];
  assign acc_lo = acc_in[H-1:0];

  always_comb begin
    if (dir_right) begin
      mem_out = {acc_lo, mem_hi};
      acc_out = {acc_hi, mem_lo};
    end else begin
      mem_out = {mem_lo, acc_lo};
      acc_out = {acc_hi, mem_hi};
    end
  end

  always_comb begin
    if (!$isunknown({dir_right, mem_in, acc_in})) begin
      // R9
      nib_perm_chk: assert ($countones({acc_out[H-1:0], mem_out}) ==
                            $countones({acc_lo, mem_in}))
        else $error("nibble rotate does not preserve the moved bits");
    end
  end
endmodule

// File: rtl/rsn_flags.sv
module rsn_flags
  import rsn_pkg::*;
(
  input  mode_e               mode,
  input  logic [DATA_W-1:0]   shift_val,
  input  logic                shift_c,
  input  logic [DATA_W-1:0]   nib_acc,
  input  logic [7:0]          flags_in,
  output logic [7:0]          flags_out
);
  logic [DATA_W-1:0] src;
  logic              nibble;

  assign nibble = mode[1];
  assign src    = nibble ? nib_acc : shift_val;

  always_comb begin
    flags_out        = '0;
    flags_out[FL_5]  = src[5];
    flags_out[FL_3]  = src[3];
    flags_out[FL_H]  = 1'b0;
    flags_out[FL_N]  = 1'b0;
    if (mode == MODE_ACC) begin
      flags_out[FL_S] = flags_in[FL_S];
      flags_out[FL_Z] = flags_in[FL_Z];
      flags_out[FL_P] = flags_in[FL_P];
    end else begin
      flags_out[FL_S] = src[DATA_W-1];
      flags_out[FL_Z] = (src == '0);
      flags_out[FL_P] = even_ones(src);
    end
    flags_out[FL_C] = nibble ? flags_in[FL_C] : shift_c;
  end

  always_comb begin
    if (!$isunknown({mode, shift_val, shift_c, nib_acc, flags_in})) begin
      // R5
      clear_hn_chk: assert (flags_out[FL_H] == 1'b0 && flags_out[FL_N] == 1'b0)
        else $error("half-carry or subtract flag left set");
    end
  end
endmodule

// File: rtl/rot_nib_unit.sv
module rot_nib_unit
  import rsn_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [CODE_W-1:0] shift_code,
  input  logic [DATA_W-1:0] operand_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] result_out,
  output logic [DATA_W-1:0] acc_out,
  output logic [7:0]        flags_out
);
  mode_e             mode;
  code_e             sh_code;
  logic [DATA_W-1:0] sh_in, sh_out, nib_mem, nib_acc;
  logic              sh_c;

  assign mode = mode_e'(mode_sel);

  // fast form works on the accumulator and knows only the four rotates
  always_comb begin
    if (mode == MODE_ACC) begin
      sh_in   = acc_in;
      sh_code = code_e'({1'b0, shift_code[1:0]});
    end else begin
      sh_in   = operand_in;
      sh_code = code_e'(shift_code);
    end
  end

  rsn_shifter #(.W(DATA_W)) u_shift (
    .din  (sh_in),
    .cin  (flags_in[FL_C]),
    .code (sh_code),
    .dout (sh_out),
    .cout (sh_c)
  );

  rsn_nibble #(.W(DATA_W)) u_nib (
    .dir_right (mode == MODE_NIB_R),
    .mem_in    (operand_in),
    .acc_in    (acc_in),
    .mem_out   (nib_mem),
    .acc_out   (nib_acc)
  );

  rsn_flags u_flg (
    .mode      (mode),
    .shift_val (sh_out),
    .shift_c   (sh_c),
    .nib_acc   (nib_acc),
    .flags_in  (flags_in),
    .flags_out (flags_out)
  );

  always_comb begin
    unique case (mode)
      MODE_FULL: begin
        result_out = sh_out;
        acc_out    = acc_in;
      end
      MODE_ACC: begin
        result_out = sh_out;
        acc_out    = sh_out;
      end
      default: begin
        result_out = nib_mem;
        acc_out    = nib_acc;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({mode_sel, shift_code, operand_in, acc_in, flags_in})) begin
      // R1
      circ_fill_chk: assert (!(mode == MODE_FULL && shift_code == 3'b000) ||
                             result_out[0] == flags_out[FL_C])
        else $error("circular rotate fill differs from carry");
      // R3
      arith_sign_chk: assert (!(mode == MODE_FULL && shift_code == 3'b101) ||
                              result_out[DATA_W-1] == operand_in[DATA_W-1])
        else $error("arithmetic right shift changed the sign bit");
      // R4
      lsr_sign_chk: assert (!(mode == MODE_FULL && shift_code == 3'b111) ||
                            flags_out[FL_S] == 1'b0)
        else $error("logical right shift left sign flag set");
      // R5
      full_acc_chk: assert (mode != MODE_FULL || acc_out == acc_in)
        else $error("full-flag form altered the accumulator");
      // R7
      acc_keep_chk: assert (mode != MODE_ACC ||
                            (flags_out[FL_S] == flags_in[FL_S] &&
                             flags_out[FL_Z] == flags_in[FL_Z] &&
                             flags_out[FL_P] == flags_in[FL_P]))
        else $error("fast form changed sign, zero or parity");
      // R10
      nib_high_chk: assert (!mode_sel[1] ||
                            acc_out[DATA_W-1:NIB_W] == acc_in[DATA_W-1:NIB_W])
        else $error("nibble rotate changed accumulator high nibble");
      // R11
      nib_carry_chk: assert (!mode_sel[1] || flags_out[FL_C] == flags_in[FL_C])
        else $error("nibble rotate changed carry");
    end
  end
endmodule

// File: tb/sim_rot_nib_unit.sv
module sim_rot_nib_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] mode_sel   = '0;
  logic [2:0] shift_code = '0;
  logic [7:0] operand_in = '0;
  logic [7:0] acc_in     = '0;
  logic [7:0] flags_in   = '0;
  logic [7:0] result_out, acc_out, flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rot_nib_unit u0 (
    .mode_sel, .shift_code, .operand_in, .acc_in, .flags_in,
    .result_out, .acc_out, .flags_out
  );

  // independent model: {result, acc, flags}
  function automatic logic [23:0] ref_model(logic [1:0] m, logic [2:0] c,
                                            logic [7:0] op, logic [7:0] acc,
                                            logic [7:0] fl);
    logic [7:0] src, r, a_new, fo;
    logic [8:0] wide;
    logic [2:0] cc;
    logic co, fill;
    if (!m[1]) begin
      src = m[0] ? acc : op;
      cc  = m[0] ? {1'b0, c[1:0]} : c;
      if (!cc[0]) begin
        case (cc[2:1])
          2'd0: fill = src[7];
          2'd1: fill = fl[0];
          2'd2: fill = 1'b0;
          default: fill = 1'b1;
        endcase
        wide = {src, fill};
        co = wide[8];
        r  = wide[7:0];
      end else begin
        case (cc[2:1])
          2'd0: fill = src[0];
          2'd1: fill = fl[0];
          2'd2: fill = src[7];
          default: fill = 1'b0;
        endcase
        wide = {fill, src};
        co = wide[0];
        r  = wide[8:1];
      end
      a_new = m[0] ? r : acc;
      if (m[0]) fo = {fl[7], fl[6], r[5], 1'b0, r[3], fl[2], 1'b0, co};
      else      fo = {r[7], (r == 8'h00), r[5], 1'b0, r[3], ~(^r), 1'b0, co};
    end else begin
      if (!m[0]) begin
        r = {op[3:0], acc[3:0]};
        a_new = {acc[7:4], op[7:4]};
      end else begin
        r = {acc[3:0], op[7:4]};
        a_new = {acc[7:4], op[3:0]};
      end
      fo = {a_new[7], (a_new == 8'h00), a_new[5], 1'b0, a_new[3], ~(^a_new), 1'b0, fl[0]};
    end
    return {r, a_new, fo};
  endfunction

  task automatic drive(logic [1:0] m, logic [2:0] c, logic [7:0] op,
                       logic [7:0] acc, logic [7:0] fl);
    @(negedge clk);
    mode_sel = m; shift_code = c; operand_in = op; acc_in = acc; flags_in = fl;
    #1;
  endtask

  task automatic check_val(string req, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_vec(string req, logic [1:0] m, logic [2:0] c, logic [7:0] op,
                         logic [7:0] acc, logic [7:0] fl);
    drive(m, c, op, acc, fl);
    check_val(req, {result_out, acc_out, flags_out}, ref_model(m, c, op, acc, fl));
  endtask

  task automatic test_idle_state;
    #1;
    // all-zero inputs: full mode code 000 on 0x00 -> zero and parity set
    check_val("R5 idle", {result_out, acc_out, flags_out}, {8'h00, 8'h00, 8'h44});
  endtask

  task automatic test_circular;
    drive(2'b00, 3'b000, 8'h81, 8'h00, 8'h00);
    check_val("R1 rot left", {result_out, acc_out, flags_out}, {8'h03, 8'h00, 8'h05});
    drive(2'b00, 3'b001, 8'h01, 8'h00, 8'h00);
    check_val("R1 rot right", {result_out, acc_out, flags_out}, {8'h80, 8'h00, 8'h81});
  endtask

  task automatic test_through;
    drive(2'b00, 3'b010, 8'h00, 8'h00, 8'h01);
    check_val("R2 thru left cin", {result_out, acc_out, flags_out}, {8'h01, 8'h00, 8'h00});
    drive(2'b00, 3'b011, 8'h01, 8'h00, 8'h00);
    check_val("R2 thru right cout", {result_out, acc_out, flags_out}, {8'h00, 8'h00, 8'h45});
  endtask

  task automatic test_arith;
    drive(2'b00, 3'b101, 8'h80, 8'h00, 8'h01);
    check_val("R3 arith right", {result_out, acc_out, flags_out}, {8'hC0, 8'h00, 8'h84});
    drive(2'b00, 3'b100, 8'hFF, 8'h00, 8'h00);
    check_val("R3 arith left", {result_out, acc_out, flags_out}, {8'hFE, 8'h00, 8'hA9});
  endtask

  task automatic test_insert;
    drive(2'b00, 3'b110, 8'h00, 8'h00, 8'h00);
    check_val("R4 ones left", {result_out, acc_out, flags_out}, {8'h01, 8'h00, 8'h00});
    drive(2'b00, 3'b111, 8'hFF, 8'h00, 8'h00);
    check_val("R4 logic right", {result_out, acc_out, flags_out}, {8'h7F, 8'h00, 8'h29});
  endtask

  task automatic sweep_full;
    for (int c = 0; c < 8; c++)
      for (int cin = 0; cin < 2; cin++)
        for (int op = 0; op < 256; op++)
          run_vec("R5 R6 full sweep", 2'b00, 3'(c), 8'(op), 8'h5A, {7'h00, 1'(cin)});
  endtask

  task automatic test_fast;
    drive(2'b01, 3'b000, 8'h00, 8'h80, 8'hC4);
    check_val("R7 fast keeps SZP", {result_out, acc_out, flags_out}, {8'h01, 8'h01, 8'hC5});
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 256; a++)
          run_vec("R7 R8 fast sweep", 2'b01, 3'(c), 8'h3C, 8'(a),
                  p ? 8'hC4 : 8'h01);
  endtask

  task automatic test_fast_bit2;
    logic [23:0] base;
    drive(2'b01, 3'b011, 8'h00, 8'h81, 8'h01);
    base = {result_out, acc_out, flags_out};
    drive(2'b01, 3'b111, 8'h00, 8'h81, 8'h01);
    check_val("R8 code bit2 ignored", {result_out, acc_out, flags_out}, base);
  endtask

  task automatic test_nibble;
    drive(2'b10, 3'b000, 8'h34, 8'h12, 8'h01);
    check_val("R9 R11 nib left", {result_out, acc_out, flags_out}, {8'h42, 8'h13, 8'h01});
    drive(2'b11, 3'b000, 8'h34, 8'h12, 8'h00);
    check_val("R10 R11 nib right", {result_out, acc_out, flags_out}, {8'h23, 8'h14, 8'h04});
    for (int m = 2; m < 4; m++)
      for (int cin = 0; cin < 2; cin++)
        for (int a = 0; a < 16; a++)
          for (int op = 0; op < 256; op++)
            run_vec(m == 2 ? "R9 R11 nib sweep" : "R10 R11 nib sweep",
                    2'(m), 3'(op), 8'(op), 8'(a * 17), {7'h00, 1'(cin)});
  endtask

  task automatic test_ignored;
    logic [23:0] base;
    drive(2'b01, 3'b010, 8'h00, 8'h96, 8'h01);
    base = {result_out, acc_out, flags_out};
    drive(2'b01, 3'b010, 8'hFF, 8'h96, 8'h01);
    check_val("R12 operand ignored in fast", {result_out, acc_out, flags_out}, base);
    drive(2'b11, 3'b000, 8'hA7, 8'h3C, 8'h01);
    base = {result_out, acc_out, flags_out};
    drive(2'b11, 3'b101, 8'hA7, 8'h3C, 8'h01);
    check_val("R12 code ignored in nibble", {result_out, acc_out, flags_out}, base);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    test_idle_state();
    test_circular();
    test_through();
    test_arith();
    test_insert();
    sweep_full();
    test_fast();
    test_fast_bit2();
    test_nibble();
    test_ignored();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule